// File: doc/BRIEF.md
# Packed Lane Adder/Subtractor

This block adds or subtracts two 64-bit operand words lane by lane. The lanes are 8, 16 or 32 bits wide. An 8-bit opcode picks the lane width, the direction and the overflow policy in one step. The opcode is the second byte of a two-byte escape-prefixed encoding. Every lane is computed on its own, so no carry or borrow crosses a lane edge. Saturating forms exist only for 8-bit and 16-bit lanes. The 32-bit lanes always wrap.

Operands enter on a valid/ready stream. The result leaves through one register stage on a second valid/ready stream. A transfer happens on a rising clock edge where valid and ready are both high. The upstream side is ready whenever the output register is empty, or when its contents are being taken in the same cycle (`in_ready = !out_valid || out_ready`). Back-pressure therefore reaches the input in the same cycle, and one transfer per cycle is sustained while the consumer stays ready. An opcode outside the supported set is still accepted. It produces a zero result with the illegal flag set.

Top module: `pkd_addsub`

## Requirements
- R1: Opcodes 0xFC, 0xFD and 0xFE add each 8-, 16- and 32-bit lane respectively, modulo 2^lane-width.
- R2: Opcodes 0xF8, 0xF9 and 0xFA subtract on 8-, 16- and 32-bit lanes modulo 2^lane-width, computing in_a lane minus in_b lane.
- R3: Opcodes 0xEC (8-bit) and 0xED (16-bit) add signed two's-complement lanes, clamping to the lane's most positive value (0x7F / 0x7FFF) or most negative value (0x80 / 0x8000) on overflow.
- R4: Opcodes 0xE8 (8-bit) and 0xE9 (16-bit) subtract signed lanes (a minus b) with the same clamping as R3.
- R5: Opcodes 0xDC (8-bit) and 0xDD (16-bit) add unsigned lanes, giving all-ones in any lane whose sum exceeds the lane range.
- R6: Opcodes 0xD8 (8-bit) and 0xD9 (16-bit) subtract unsigned lanes (a minus b), giving zero in any lane where b is greater than a.
- R7: A carry or borrow produced in one lane never changes any other lane of the result.
- R8: Any opcode not listed in R1 to R6 yields out_illegal = 1 and out_result = 0. Every listed opcode yields out_illegal = 0.
- R9: While out_valid is high and out_ready is low, out_valid, out_result and out_illegal hold steady and in_ready is low. When out_ready is high or out_valid is low, in_ready is high.
- R10: While rst_n is low and in the first cycle after it, out_valid is 0. Data accepted on a clock edge appears on out_valid/out_result on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand stream: opcode and operands are valid |
| in_ready | output | 1 | Operand stream: block can take a new operation |
| in_opcode | input | 8 | Operation selector byte |
| in_a | input | 64 | First operand (minuend for subtraction) |
| in_b | input | 64 | Second operand (subtrahend for subtraction) |
| out_valid | output | 1 | Result stream: result is valid |
| out_ready | input | 1 | Result stream: consumer takes the result |
| out_result | output | 64 | Packed lane result |
| out_illegal | output | 1 | Set with the result when the opcode was unsupported |

## Verification
The bench builds the block with its default 64-bit data width. At that width there are eight byte lanes, four halfword lanes and two word lanes, so carry isolation is tested at every lane boundary for each lane size. A reference model computes each lane from the requirement text, using wide integer arithmetic. The bench checks it with hand-picked saturation edges (0x7F+1, 0x80-1, 0xFF+1, 0-1) and with a set of pseudo-random operand words for every opcode. A held-consumer scenario then covers the stall path. A second input is offered during that stall and must not be taken early.

// File: rtl/pkd_pkg.sv
package pkd_pkg;

  typedef enum logic [1:0] {
    LW_8  = 2'd0,
    LW_16 = 2'd1,
    LW_32 = 2'd2
  } lane_w_e;

  typedef enum logic [1:0] {
    OV_WRAP = 2'd0,
    OV_SSAT = 2'd1,
    OV_USAT = 2'd2
  } ovf_e;

  typedef struct packed {
    logic    legal;
    logic    sub;
    lane_w_e width;
    ovf_e    ovf;
  } op_ctl_t;

  localparam int unsigned NUM_WIDTHS = 3;
  localparam int unsigned MIN_LANE_W = 8;

endpackage

// File: rtl/pkd_decode.sv
module pkd_decode
  import pkd_pkg::*;
(
  input  logic [7:0] opcode,
  output op_ctl_t    ctl
);

  always_comb begin
    ctl = '{legal: 1'b1, sub: 1'b0, width: LW_8, ovf: OV_WRAP};
    case (opcode)
      8'hFC: begin ctl.width = LW_8;  end
      8'hFD: begin ctl.width = LW_16; end
      8'hFE: begin ctl.width = LW_32; end
      8'hF8: begin ctl.width = LW_8;  ctl.sub = 1'b1; end
      8'hF9: begin ctl.width = LW_16; ctl.sub = 1'b1; end
      8'hFA: begin ctl.width = LW_32; ctl.sub = 1'b1; end
      8'hEC: begin ctl.width = LW_8;  ctl.ovf = OV_SSAT; end
      8'hED: begin ctl.width = LW_16; ctl.ovf = OV_SSAT; end
      8'hE8: begin ctl.width = LW_8;  ctl.ovf = OV_SSAT; ctl.sub = 1'b1; end
      8'hE9: begin ctl.width = LW_16; ctl.ovf = OV_SSAT; ctl.sub = 1'b1; end
      8'hDC: begin ctl.width = LW_8;  ctl.ovf = OV_USAT; end
      8'hDD: begin ctl.width = LW_16; ctl.ovf = OV_USAT; end
      8'hD8: begin ctl.width = LW_8;  ctl.ovf = OV_USAT; ctl.sub = 1'b1; end
      8'hD9: begin ctl.width = LW_16; ctl.ovf = OV_USAT; ctl.sub = 1'b1; end
      default: begin ctl.legal = 1'b0; end
    endcase
  end

endmodule

// File: rtl/pkd_lane.sv
module pkd_lane
  import pkd_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  ovf_e         ovf,
  output logic [W-1:0] y
);

  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] b_eff;
  logic [W:0]   sum;
  logic         u_hit;
  logic         s_hit;

  // Subtraction as a + ~b + 1; the lane's own carry-in keeps it isolated.
  assign b_eff = sub ? ~b : b;
  assign sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};

  // Carry out on add, or no carry out (a borrow) on subtract.
  assign u_hit = sub ? ~sum[W] : sum[W];
  // Signed overflow: same-sign inputs give a result of the other sign.
  assign s_hit = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);

  always_comb begin
    y = sum[W-1:0];
    case (ovf)
      OV_SSAT: if (s_hit) y = a[W-1] ? S_MIN : S_MAX;
      OV_USAT: if (u_hit) y = sub ? '0 : '1;
      default: y = sum[W-1:0];
    endcase
  end

endmodule

// File: rtl/pkd_datapath.sv
module pkd_datapath
  import pkd_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  op_ctl_t           ctl,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] res_by_w [NUM_WIDTHS];

  for (genvar gw = 0; gw < NUM_WIDTHS; gw++) begin : g_width
    localparam int unsigned LW = MIN_LANE_W << gw;
    localparam int unsigned NL = DATA_W / LW;
    for (genvar gl = 0; gl < NL; gl++) begin : g_lane
      pkd_lane #(.W(LW)) u_lane (
        .a   (a[gl*LW +: LW]),
        .b   (b[gl*LW +: LW]),
        .sub (ctl.sub),
        .ovf (ctl.ovf),
        .y   (res_by_w[gw][gl*LW +: LW])
      );
    end
  end

  always_comb begin
    result = '0;
    if (ctl.legal) begin
      case (ctl.width)
        LW_8:    result = res_by_w[0];
        LW_16:   result = res_by_w[1];
        LW_32:   result = res_by_w[2];
        default: result = '0;
      endcase
    end
  end

endmodule

// File: rtl/pkd_ostage.sv
module pkd_ostage #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_flag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_flag
);

  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_data <= in_data;
      out_flag <= in_flag;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_flag)));

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R8
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flag) |-> (out_data == '0));

endmodule

// File: rtl/pkd_addsub.sv
module pkd_addsub
  import pkd_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_opcode,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_illegal
);

  localparam int unsigned NBYTE = DATA_W / 8;

  op_ctl_t           ctl;
  logic [DATA_W-1:0] dp_res;

  pkd_decode u_dec (
    .opcode (in_opcode),
    .ctl    (ctl)
  );

  pkd_datapath #(.DATA_W(DATA_W)) u_dp (
    .a      (in_a),
    .b      (in_b),
    .ctl    (ctl),
    .result (dp_res)
  );

  pkd_ostage #(.DATA_W(DATA_W)) u_os (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (dp_res),
    .in_flag   (!ctl.legal),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_result),
    .out_flag  (out_illegal)
  );

  for (genvar gb = 0; gb < NBYTE; gb++) begin : g_chk
    // R5
    usat_add_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_opcode == 8'hDC) |-> (dp_res[gb*8 +: 8] >= in_a[gb*8 +: 8]));
    // R6
    usat_sub_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_opcode == 8'hD8) |-> (dp_res[gb*8 +: 8] <= in_a[gb*8 +: 8]));
    // R3
    ssat_add_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_opcode == 8'hEC && !in_a[gb*8+7] && !in_b[gb*8+7])
        |-> !dp_res[gb*8+7]);
  end

endmodule

// File: tb/pkd_addsub_tb.sv
module pkd_addsub_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_opcode = 8'h00;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_illegal;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pkd_addsub dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_illegal(out_illegal)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Reference: decode per requirements R1..R6, anything else illegal (R8).
  function automatic logic [63:0] model(input logic [7:0] op, input logic [63:0] a,
                                        input logic [63:0] b, output logic ill);
    int w; bit sub; int mode; longint x, y, s, m, h;
    logic [63:0] r;
    ill = 1'b0; sub = 0; mode = 0; w = 8; r = '0;
    case (op)
      8'hFC: w = 8;  8'hFD: w = 16; 8'hFE: w = 32;
      8'hF8: begin w = 8;  sub = 1; end
      8'hF9: begin w = 16; sub = 1; end
      8'hFA: begin w = 32; sub = 1; end
      8'hEC: begin w = 8;  mode = 1; end
      8'hED: begin w = 16; mode = 1; end
      8'hE8: begin w = 8;  mode = 1; sub = 1; end
      8'hE9: begin w = 16; mode = 1; sub = 1; end
      8'hDC: begin w = 8;  mode = 2; end
      8'hDD: begin w = 16; mode = 2; end
      8'hD8: begin w = 8;  mode = 2; sub = 1; end
      8'hD9: begin w = 16; mode = 2; sub = 1; end
      default: ill = 1'b1;
    endcase
    if (ill) return '0;
    m = (longint'(1) << w) - 1;
    h = longint'(1) << (w - 1);
    for (int i = 0; i < 64 / w; i++) begin
      x = longint'((a >> (i * w))) & m;
      y = longint'((b >> (i * w))) & m;
      if (mode == 1) begin
        if (x >= h) x = x - (h << 1);
        if (y >= h) y = y - (h << 1);
      end
      s = sub ? x - y : x + y;
      if (mode == 1) begin
        if (s > h - 1) s = h - 1;
        if (s < -h) s = -h;
      end else if (mode == 2) begin
        if (s > m) s = m;
        if (s < 0) s = 0;
      end
      r = r | (64'(s & m) << (i * w));
    end
    return r;
  endfunction

  task automatic run_op(input string tag, input logic [7:0] op,
                        input logic [63:0] a, input logic [63:0] b);
    logic [63:0] exp; logic ill;
    exp = model(op, a, b, ill);
    @(negedge clk);
    in_valid = 1'b1; in_opcode = op; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid"}, {63'd0, out_valid}, 64'd1);
    chk({tag, " result"}, out_result, exp);
    chk({tag, " illegal"}, {63'd0, out_illegal}, {63'd0, ill});
  endtask

  task automatic rand_ops(input string tag, input logic [7:0] op);
    for (int k = 0; k < 6; k++) run_op(tag, op, {$urandom, $urandom}, {$urandom, $urandom});
  endtask

  task automatic t_reset;
    chk("R10 reset out_valid", {63'd0, out_valid}, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    chk("R10 post-reset out_valid", {63'd0, out_valid}, 64'd0);
    chk("R9 idle in_ready", {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_wrap_add; // R1
    run_op("R1 byte wrap", 8'hFC, 64'hFF80_7F01_00FF_1234, 64'h0180_0101_FF01_4321);
    run_op("R1 half wrap", 8'hFD, 64'hFFFF_8000_7FFF_0001, 64'h0001_8000_0001_FFFF);
    run_op("R1 word wrap", 8'hFE, 64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0001_0000_0001);
    rand_ops("R1 rnd b", 8'hFC); rand_ops("R1 rnd h", 8'hFD); rand_ops("R1 rnd w", 8'hFE);
  endtask

  task automatic t_wrap_sub; // R2
    run_op("R2 byte wrap", 8'hF8, 64'h0000_8010_0102_0300, 64'h0100_0120_0201_0001);
    run_op("R2 half wrap", 8'hF9, 64'h0000_8000_1234_0005, 64'h0001_0001_1234_0007);
    run_op("R2 word wrap", 8'hFA, 64'h0000_0000_8000_0000, 64'h0000_0001_0000_0001);
    rand_ops("R2 rnd b", 8'hF8); rand_ops("R2 rnd h", 8'hF9); rand_ops("R2 rnd w", 8'hFA);
  endtask

  task automatic t_ssat; // R3, R4
    run_op("R3 byte sat", 8'hEC, 64'h7F80_7F80_4040_C0C0, 64'h0101_8080_4141_BFBF);
    run_op("R3 half sat", 8'hED, 64'h7FFF_8000_4000_C000, 64'h0001_FFFF_4000_BFFF);
    run_op("R4 byte sat", 8'hE8, 64'h807F_8000_7F00_0101, 64'h0180_0101_FF80_0202);
    run_op("R4 half sat", 8'hE9, 64'h8000_7FFF_0000_1234, 64'h0001_FFFF_8000_1235);
    rand_ops("R3 rnd b", 8'hEC); rand_ops("R3 rnd h", 8'hED);
    rand_ops("R4 rnd b", 8'hE8); rand_ops("R4 rnd h", 8'hE9);
  endtask

  task automatic t_usat; // R5, R6
    run_op("R5 byte sat", 8'hDC, 64'hFF80_01FE_0000_7F80, 64'h0180_FE01_0000_8080);
    run_op("R5 half sat", 8'hDD, 64'hFFFF_8000_0001_1234, 64'h0001_8000_FFFE_0001);
    run_op("R6 byte sat", 8'hD8, 64'h0001_FF00_8080_1020, 64'h0102_FE01_8081_0F30);
    run_op("R6 half sat", 8'hD9, 64'h0000_FFFF_1000_0005, 64'h0001_FFFE_1001_0006);
    rand_ops("R5 rnd b", 8'hDC); rand_ops("R5 rnd h", 8'hDD);
    rand_ops("R6 rnd b", 8'hD8); rand_ops("R6 rnd h", 8'hD9);
  endtask

  task automatic t_lane_iso; // R7: every lane overflows, neighbours must not see it
    run_op("R7 byte carry", 8'hFC, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101);
    run_op("R7 half carry", 8'hFD, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001);
    run_op("R7 word carry", 8'hFE, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001);
    run_op("R7 byte borrow", 8'hF8, 64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101);
    run_op("R7 word borrow", 8'hFA, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001);
  endtask

  task automatic t_illegal; // R8
    logic [7:0] bad_ops [8] = '{8'h00, 8'h0F, 8'hFB, 8'hDE, 8'hEA, 8'hFF, 8'hEE, 8'hDA};
    for (int k = 0; k < 8; k++)
      run_op("R8 illegal", bad_ops[k], 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321);
  endtask

  task automatic t_stall; // R9
    logic [63:0] e1, e2; logic ill;
    e1 = model(8'hFC, 64'h0102_0304_0506_0708, 64'h1010_1010_1010_1010, ill);
    e2 = model(8'hF9, 64'h5555_5555_5555_5555, 64'h1111_1111_1111_1111, ill);
    @(negedge clk);
    @(negedge clk);
    chk("R9 drained", {63'd0, out_valid}, 64'd0);
    out_ready = 1'b0;
    in_valid = 1'b1; in_opcode = 8'hFC;
    in_a = 64'h0102_0304_0506_0708; in_b = 64'h1010_1010_1010_1010;
    @(negedge clk);
    in_opcode = 8'hF9; in_a = 64'h5555_5555_5555_5555; in_b = 64'h1111_1111_1111_1111;
    for (int k = 0; k < 3; k++) begin
      chk("R9 stall valid", {63'd0, out_valid}, 64'd1);
      chk("R9 stall ready", {63'd0, in_ready}, 64'd0);
      chk("R9 stall hold", out_result, e1);
      @(negedge clk);
    end
    out_ready = 1'b1;
    #1 chk("R9 release ready", {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 second result", out_result, e2);
    chk("R10 second valid", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    chk("R9 consumed", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_wrap_add();
    t_wrap_sub();
    t_ssat();
    t_usat();
    t_lane_iso();
    t_illegal();
    t_stall();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule